// File: doc/BRIEF.md
# Two-Wire Register Control Port

This block is a slave on a two-wire serial control bus (I2C-compatible). It gives a bus master write and read-back access to a bank of 256 byte-wide control registers, which sit outside the block. The block drives a one-cycle write strobe with an address and data toward that register file. It presents a read address and takes the returned byte combinationally.

Both bus lines are sampled on a fast system clock through flop synchronisers. Line edges and bus conditions are detected in that clock domain. The data line is driven open-drain: the block only asserts an output enable that pulls the line low. The 7-bit device address comes from a fixed base byte with two strap inputs placed in fixed bit positions, so four such ports can share one bus.

A write frame sets the internal register pointer and then stores one or more data bytes. A read frame first sets the pointer with a write frame. It then uses a repeated START and an address byte with the read bit set, after which the block shifts out register contents until the master declines a byte.

Top module: `i2c_regport`

## Requirements
- R1: The first byte after a START is compared with a device byte formed from the base 0x04, with strap_a0 placed at bit 5 and strap_a1 at bit 6 (0x04, 0x24, 0x44, 0x64 for straps 00, 01, 10, 11). Bits 7..1 must match, and bit 0 is the direction (1 = read). On a match the block pulls SDA low for the whole ninth SCL pulse.
- R2: On an address mismatch the block never pulls SDA low and never strobes a write, and it leaves the pointer unchanged until the next START or STOP.
- R3: In a write frame the second byte loads the register pointer. Each further byte gives exactly one single-cycle reg_wr_en, with reg_wr_addr equal to the pointer and reg_wr_data equal to the byte. Every received byte is acknowledged.
- R4: The pointer, visible on reg_rd_addr, advances by one after every data byte written or read, and wraps from 0xFF to 0x00.
- R5: After a pointer write, a repeated START and an address byte with bit 0 set, the block shifts the byte at the pointer out MSB first, one bit per SCL pulse. After each byte the master acknowledges, it continues with the next register.
- R6: When the master answers a read byte with NACK (SDA high on the ninth pulse), the block releases SDA and drives nothing more until a START or STOP.
- R7: A START in any state, including mid-byte, restarts address reception. A STOP returns the block to idle. Both release SDA.
- R8: The block only begins pulling SDA low while SCL is low, so its own SDA changes never form a START or STOP.
- R9: After reset sda_oe and reg_wr_en are 0 and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_a0 | input | 1 | Address strap, device byte bit 5 |
| strap_a1 | input | 1 | Address strap, device byte bit 6 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_wr_addr | output | 8 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_addr | output | 8 | Register pointer, used as read address |
| reg_rd_data | input | 8 | Register contents at reg_rd_addr |

## Verification
The bench builds the block with its default two synchroniser stages and base byte 0x04. With an SCL half period of 40 system clocks the synchroniser delay stays well inside each bus phase. This brings within reach all four strap settings, a strap-mismatched address, and a pointer that runs across the 0xFF to 0x00 wrap during both a write burst and a read burst. It also covers a START that cuts a byte off after four bits, and a read ended by master NACK followed by an extra clocked byte that must read back all ones.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BITS  = 9;
    localparam int CNT_W       = $clog2(FRAME_BITS + 1);
    localparam int STRAP0_BIT  = 5;
    localparam int STRAP1_BIT  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WR,
        ST_RD,
        ST_SKIP
    } port_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // Device byte: base with the two straps overlaid in their fixed positions.
    function automatic logic [BYTE_W-1:0] dev_byte(input logic [BYTE_W-1:0] base,
                                                   input logic s1, input logic s0);
        logic [BYTE_W-1:0] b;
        b = base;
        b[STRAP0_BIT] = s0;
        b[STRAP1_BIT] = s1;
        return b;
    endfunction

endpackage

// File: rtl/i2cp_sync.sv
module i2cp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= 1'b1;
                else     chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cp_cond.sv
module i2cp_cond
    import i2cp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    always_comb begin
        evt.rise  = scl & ~scl_d;
        evt.fall  = ~scl & scl_d;
        evt.start = scl & scl_d & sda_d & ~sda;
        evt.stop  = scl & scl_d & ~sda_d & sda;
    end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2cp_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] BASE_BYTE   = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_a0,
    input  logic              strap_a1,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_addr,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic [BYTE_W-1:0] reg_rd_addr,
    input  logic [BYTE_W-1:0] reg_rd_data
);
    localparam logic [CNT_W-1:0] SLOT_OPEN  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] SLOT_CLOSE = CNT_W'(FRAME_BITS);

    // line index 0 = SCL, 1 = SDA
    logic [1:0] raw_lines, sync_lines;
    assign raw_lines = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            i2cp_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (raw_lines[g]),
                .q   (sync_lines[g])
            );
        end
    endgenerate

    bus_evt_t evt;
    i2cp_cond u_cond (
        .clk (clk),
        .rst (rst),
        .scl (sync_lines[0]),
        .sda (sync_lines[1]),
        .evt (evt)
    );

    port_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg, ptr, my_byte;
    logic              rw, mnack, match;
    logic [2:0]        bidx;

    assign my_byte     = dev_byte(BASE_BYTE, strap_a1, strap_a0);
    assign match       = (shreg[BYTE_W-1:1] == my_byte[BYTE_W-1:1]);
    assign bidx        = 3'd7 - cnt[2:0];
    assign reg_rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            shreg       <= '0;
            rw          <= 1'b0;
            mnack       <= 1'b1;
            ptr         <= '0;
            sda_oe      <= 1'b0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (state == ST_IDLE || state == ST_SKIP) begin
                cnt <= cnt;
            end else if (evt.rise) begin
                cnt <= cnt + 1'b1;
                if (cnt < SLOT_OPEN && state != ST_RD)
                    shreg <= {shreg[BYTE_W-2:0], sync_lines[1]};
                if (cnt == SLOT_OPEN)
                    mnack <= sync_lines[1];
            end else if (evt.fall) begin
                if (cnt == SLOT_OPEN) begin
                    case (state)
                        ST_ADDR: begin
                            if (match) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                            end else begin
                                state  <= ST_SKIP;
                            end
                        end
                        ST_PTR: begin
                            ptr    <= shreg;
                            sda_oe <= 1'b1;
                        end
                        ST_WR: begin
                            reg_wr_en   <= 1'b1;
                            reg_wr_addr <= ptr;
                            reg_wr_data <= shreg;
                            ptr         <= ptr + 1'b1;
                            sda_oe      <= 1'b1;
                        end
                        ST_RD: begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else if (cnt == SLOT_CLOSE) begin
                    cnt    <= '0;
                    sda_oe <= 1'b0;
                    case (state)
                        ST_ADDR: begin
                            if (rw) begin
                                state  <= ST_RD;
                                shreg  <= reg_rd_data;
                                sda_oe <= ~reg_rd_data[BYTE_W-1];
                            end else begin
                                state  <= ST_PTR;
                            end
                        end
                        ST_PTR: state <= ST_WR;
                        ST_RD: begin
                            if (mnack) begin
                                state  <= ST_SKIP;
                            end else begin
                                shreg  <= reg_rd_data;
                                sda_oe <= ~reg_rd_data[BYTE_W-1];
                            end
                        end
                        default: state <= state;
                    endcase
                end else if (state == ST_RD) begin
                    sda_oe <= ~shreg[bidx];
                end
            end
        end
    end

    // R8: the slave starts pulling SDA low only while SCL is low
    a_r8_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !sync_lines[0]);

    // R7: START restarts address reception with SDA released
    a_r7_start_abort: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_ADDR && !sda_oe));

    // R7: STOP returns to idle with SDA released
    a_r7_stop_idle: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE && !sda_oe));

    // R2 / R6: an ignored or finished transfer never pulls SDA
    a_r2_skip_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !sda_oe);

    // R3: write strobe lasts one cycle
    a_r3_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    // R4: pointer already stands one past the byte being written
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> (reg_rd_addr == BYTE_W'(reg_wr_addr + 1'b1)));
endmodule

// File: tb/i2c_regport_tb_top.sv
module i2c_regport_tb_top;
    localparam int H = 40;   // SCL half period in system clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;    // 250 MHz

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic strap_a0 = 1'b0, strap_a1 = 1'b0;
    logic sda_oe, reg_wr_en;
    logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;
    logic sda_bus;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_regport dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_a0(strap_a0), .strap_a1(strap_a1), .sda_oe(sda_oe),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    // external register file model
    logic [7:0] rf [256];
    logic [7:0] exp_mem [256];
    initial for (int i = 0; i < 256; i++) begin rf[i] = 8'h00; exp_mem[i] = 8'h00; end
    always @(posedge clk) if (reg_wr_en) rf[reg_wr_addr] <= reg_wr_data;
    assign reg_rd_data = rf[reg_rd_addr];

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard of expected write strobes {addr, data}
    logic [15:0] wq [$];
    task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
        wq.push_back({a, d});
        exp_mem[a] = d;
    endtask

    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr_en) begin
                if (wq.size() == 0) begin
                    check(0, "R3/R2 unexpected write strobe", {reg_wr_addr, reg_wr_data}, 0);
                end else begin
                    logic [15:0] e;
                    e = wq.pop_front();
                    check({reg_wr_addr, reg_wr_data} == e, "R3 write strobe addr/data",
                          {reg_wr_addr, reg_wr_data}, e);
                end
            end
            if (sda_oe && !oe_prev && scl_m)
                check(0, "R8 SDA pulled while SCL high", 1, 0);
            oe_prev = sda_oe;
        end
    end

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wc(H/2); scl_m = 1'b1; wc(H);
        sda_m = 1'b0; wc(H); scl_m = 1'b0; wc(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wc(H/2); scl_m = 1'b1; wc(H);
        sda_m = 1'b1; wc(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wc(H/2); scl_m = 1'b1; wc(H); scl_m = 1'b0; wc(H/2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wc(H/2); scl_m = 1'b1; wc(H/2);
        ack = sda_bus; wc(H/2); scl_m = 1'b0; wc(H/2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wc(H/2); scl_m = 1'b1; wc(H/2);
            b[i] = sda_bus; wc(H/2); scl_m = 1'b0; wc(H/2);
        end
        sda_m = nack; wc(H/2); scl_m = 1'b1; wc(H); scl_m = 1'b0; wc(H/2);
        sda_m = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        wc(5); rst = 1'b0; wc(5);
        check(sda_oe == 0, "R9 reset sda_oe", sda_oe, 0);
        check(reg_wr_en == 0, "R9 reset reg_wr_en", reg_wr_en, 0);
        check(reg_rd_addr == 0, "R9 reset pointer", reg_rd_addr, 0);

        // straps 01 -> device byte 0x24, write two bytes at 0x10
        strap_a0 = 1'b1; strap_a1 = 1'b0; wc(4);
        bus_start();
        send_byte(8'h24, a); check(a == 0, "R1 ack device 0x24", a, 0);
        send_byte(8'h10, a); check(a == 0, "R3 ack pointer byte", a, 0);
        push_wr(8'h10, 8'hA5);
        send_byte(8'hA5, a); check(a == 0, "R3 ack data byte", a, 0);
        push_wr(8'h11, 8'h3C);
        send_byte(8'h3C, a); check(a == 0, "R3 ack second data byte", a, 0);
        bus_stop();
        check(reg_rd_addr == 8'h12, "R4 pointer after two writes", reg_rd_addr, 8'h12);

        // read back with repeated start
        bus_start();
        send_byte(8'h24, a); send_byte(8'h10, a);
        bus_start();
        send_byte(8'h25, a); check(a == 0, "R5 ack read address", a, 0);
        recv_byte(b, 1'b0); check(b == exp_mem[8'h10], "R5 read byte 0x10", b, exp_mem[8'h10]);
        recv_byte(b, 1'b1); check(b == exp_mem[8'h11], "R5 read byte 0x11", b, exp_mem[8'h11]);
        recv_byte(b, 1'b1); check(b == 8'hFF, "R6 released after NACK", b, 8'hFF);
        bus_stop();
        check(reg_rd_addr == 8'h12, "R4 pointer after two reads", reg_rd_addr, 8'h12);

        // address mismatch with straps 01
        bus_start();
        send_byte(8'h44, a); check(a == 1, "R2 no ack on 0x44", a, 1);
        send_byte(8'h00, a); check(a == 1, "R2 no ack on later byte", a, 1);
        send_byte(8'h55, a); check(a == 1, "R2 no ack on data", a, 1);
        bus_stop();
        check(reg_rd_addr == 8'h12, "R2 pointer untouched", reg_rd_addr, 8'h12);

        // straps 10 -> 0x44, wrap across 0xFF
        strap_a0 = 1'b0; strap_a1 = 1'b1; wc(4);
        bus_start();
        send_byte(8'h44, a); check(a == 0, "R1 ack device 0x44", a, 0);
        send_byte(8'hFF, a);
        push_wr(8'hFF, 8'h11); send_byte(8'h11, a);
        push_wr(8'h00, 8'h22); send_byte(8'h22, a);
        bus_stop();
        check(reg_rd_addr == 8'h01, "R4 pointer wrap on write", reg_rd_addr, 8'h01);
        bus_start();
        send_byte(8'h44, a); send_byte(8'hFF, a);
        bus_start();
        send_byte(8'h45, a);
        recv_byte(b, 1'b0); check(b == 8'h11, "R4 read at 0xFF", b, 8'h11);
        recv_byte(b, 1'b1); check(b == 8'h22, "R4 read after wrap", b, 8'h22);
        bus_stop();

        // START mid-byte aborts
        bus_start();
        send_byte(8'h44, a); send_byte(8'h40, a);
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(8'h44, a); check(a == 0, "R7 ack after mid-byte START", a, 0);
        send_byte(8'h41, a);
        push_wr(8'h41, 8'h99); send_byte(8'h99, a);
        bus_stop();
        wc(8);
        check(sda_oe == 0, "R7 SDA released after STOP", sda_oe, 0);
        bus_start();
        send_byte(8'h44, a); send_byte(8'h41, a);
        bus_start();
        send_byte(8'h45, a);
        recv_byte(b, 1'b1); check(b == 8'h99, "R7 data written after abort", b, 8'h99);
        bus_stop();

        // straps 11 and 00
        strap_a0 = 1'b1; strap_a1 = 1'b1; wc(4);
        bus_start(); send_byte(8'h64, a); check(a == 0, "R1 ack device 0x64", a, 0); bus_stop();
        strap_a0 = 1'b0; strap_a1 = 1'b0; wc(4);
        bus_start(); send_byte(8'h04, a); check(a == 0, "R1 ack device 0x04", a, 0); bus_stop();
        bus_start(); send_byte(8'h64, a); check(a == 1, "R2 no ack 0x64 at straps 00", a, 1); bus_stop();

        wc(10);
        check(wq.size() == 0, "R3 all expected writes seen", wq.size(), 0);
        done = 1;
        finish_run();
    end
endmodule